// File: doc/BRIEF.md
# Delayed-Edge Scanline Interrupt Timer

This block is the interrupt timer of a cartridge controller. It counts events and raises a level interrupt when an 8-bit down-counter with reload semantics reaches zero while interrupts are enabled. In edge mode an event is a rising edge on bit 12 of the video address bus. The edge does not clock the counter at once. It arms a countdown of 25 video ticks, and the event fires when that countdown expires. In cycle mode the same countdown runs freely with a period of 12 ticks, so the counter steps once every 12 ticks.

The CPU programs the block through write strobes. The address is reduced to its two top bits and bit 0, which selects one of four offsets: the reload value, the mode together with a reload request, interrupt disable with acknowledge, and interrupt enable. A single-cycle `tick` enable marks each video clock. The video address bit is sampled only on ticks. The interrupt output is a level that stays high until a disable write acknowledges it.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset, `irq` is low and the counter, countdown, reload value, mode, enable, reload request and previous bit-12 sample are all zero.
- R2: A write is decoded from address bits 14, 13 and 0 only, and all other address bits are ignored. Bits 14:13 = 2'b10 with bit 0 = 0 stores `cpu_data` as the reload value and leaves the running counter unchanged.
- R3: A write with bits 14:13 = 2'b10 and bit 0 = 1 sets the mode from data bit 0 (1 = cycle mode, 0 = edge mode) and requests a reload. When data bit 0 is 1, the same write also loads the countdown with 12.
- R4: On a counter event with a reload requested, the counter loads the reload value plus one and the request is cleared. A reload value of 255 gives 256 without wrapping.
- R5: On a counter event with no reload requested and the counter at zero, the counter loads the reload value and no interrupt is raised.
- R6: On a counter event with a nonzero counter, the counter decrements. If the result is zero and interrupts are enabled, the interrupt becomes pending. If interrupts are disabled, nothing becomes pending.
- R7: On a tick where `vaddr12` is 1 and its previous tick sample was 0, the countdown loads 25. The counter event follows on the 25th later tick. Holding `vaddr12` high makes no further edges.
- R8: In edge mode, an expired countdown stays at zero. No further events occur without a new edge.
- R9: In cycle mode, an expired countdown reloads to 12, which gives one event every 12 ticks.
- R10: When an edge and a countdown expiry fall on the same tick, the expiry event is issued and the countdown then holds 25.
- R11: A write with bits 14:13 = 2'b11 and bit 0 = 0 disables interrupts and clears the pending interrupt. With bit 0 = 1 the write enables interrupts and clears nothing.
- R12: `irq` equals the pending-interrupt flag and changes only on a counter event or an acknowledge write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 15 | CPU write address within the cartridge window |
| cpu_data | input | 8 | CPU write data |
| tick | input | 1 | Video clock enable, one cycle per video tick |
| vaddr12 | input | 1 | Bit 12 of the video address bus |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `tick` is a clean one-cycle enable and that `vaddr12` is meaningful only in tick cycles. They also assume that a CPU write in the same cycle as an expiry follows the fixed priority, where writes override the timer's result. The stimulus issues writes only in cycles without a tick. It changes `vaddr12` only between ticks, so every edge lands on a known tick. The one case where an edge and an expiry coincide is placed on purpose, by counting ticks from a countdown load of 12.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Decoded CPU write commands, at most one set per cycle
    typedef struct packed {
        logic ld_reload;   // store reload value
        logic ld_mode;     // set mode, request reload
        logic irq_off;     // disable and acknowledge
        logic irq_on;      // enable
    } cmd_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
    parameter int ADDR_W = 15
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output irqc_pkg::cmd_t    cmd
);
    logic [1:0] sel;
    logic       odd;
    logic       unused_addr_bits;

    assign sel              = addr[ADDR_W-1 -: 2];
    assign odd              = addr[0];
    assign unused_addr_bits = ^addr[ADDR_W-3:1];

    always_comb begin
        cmd           = '0;
        cmd.ld_reload = wr && (sel == 2'b10) && !odd;
        cmd.ld_mode   = wr && (sel == 2'b10) &&  odd;
        cmd.irq_off   = wr && (sel == 2'b11) && !odd;
        cmd.irq_on    = wr && (sel == 2'b11) &&  odd;
    end
endmodule

// File: rtl/irqc_delay.sv
module irqc_delay #(
    parameter int EDGE_DELAY   = 25,
    parameter int CYCLE_PERIOD = 12,
    localparam int CD_W        = $clog2(EDGE_DELAY + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            vaddr12,
    input  logic            ld_mode,
    input  logic            mode_bit,
    output logic            ev,
    output logic [CD_W-1:0] cd,
    output logic            a12_prev
);
    typedef struct packed {
        logic [CD_W-1:0] cd;
        logic            a12_prev;
        logic            cyc_mode;
    } dly_t;

    dly_t dly_d, dly_q;
    logic ev_d;

    always_comb begin
        dly_d = dly_q;
        ev_d  = 1'b0;
        if (tick) begin
            dly_d.a12_prev = vaddr12;
            if (dly_q.cd != '0) begin
                dly_d.cd = dly_q.cd - CD_W'(1);
                if (dly_q.cd == CD_W'(1)) begin
                    ev_d     = 1'b1;
                    dly_d.cd = dly_q.cyc_mode ? CD_W'(CYCLE_PERIOD) : '0;
                end
            end
            // edge load wins over the expiry reload
            if (vaddr12 && !dly_q.a12_prev) begin
                dly_d.cd = CD_W'(EDGE_DELAY);
            end
        end
        // CPU write applied last
        if (ld_mode) begin
            dly_d.cyc_mode = mode_bit;
            if (mode_bit) begin
                dly_d.cd = CD_W'(CYCLE_PERIOD);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_d;
        end
    end

    assign ev       = ev_d;
    assign cd       = dly_q.cd;
    assign a12_prev = dly_q.a12_prev;
endmodule

// File: rtl/irqc_count.sv
module irqc_count #(
    parameter int DATA_W  = 8,
    localparam int CNT_W  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev,
    input  irqc_pkg::cmd_t    cmd,
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] reload,
    output logic              pend,
    output logic              irq
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] reload;
        logic              pend;
        logic              en;
        logic              irq;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ev) begin
            if (ctr_q.pend) begin
                ctr_d.cnt  = {1'b0, ctr_q.reload} + CNT_W'(1);
                ctr_d.pend = 1'b0;
            end else if (ctr_q.cnt == '0) begin
                ctr_d.cnt = {1'b0, ctr_q.reload};
            end else begin
                ctr_d.cnt = ctr_q.cnt - CNT_W'(1);
                if (ctr_q.cnt == CNT_W'(1) && ctr_q.en) begin
                    ctr_d.irq = 1'b1;
                end
            end
        end
        if (cmd.ld_reload) ctr_d.reload = data;
        if (cmd.ld_mode)   ctr_d.pend   = 1'b1;
        if (cmd.irq_off) begin
            ctr_d.en  = 1'b0;
            ctr_d.irq = 1'b0;
        end
        if (cmd.irq_on)    ctr_d.en     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt    = ctr_q.cnt;
    assign reload = ctr_q.reload;
    assign pend   = ctr_q.pend;
    assign irq    = ctr_q.irq;
endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 15,
    parameter int EDGE_DELAY   = 25,
    parameter int CYCLE_PERIOD = 12,
    localparam int CD_W        = $clog2(EDGE_DELAY + 1),
    localparam int CNT_W       = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              tick,
    input  logic              vaddr12,
    output logic              irq
);
    irqc_pkg::cmd_t    cmd;
    logic              ev;
    logic [CD_W-1:0]   cd;
    logic              a12_prev;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] reload;
    logic              pend;

    irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (cpu_wr),
        .addr (cpu_addr),
        .cmd  (cmd)
    );

    irqc_delay #(
        .EDGE_DELAY  (EDGE_DELAY),
        .CYCLE_PERIOD(CYCLE_PERIOD)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .vaddr12  (vaddr12),
        .ld_mode  (cmd.ld_mode),
        .mode_bit (cpu_data[0]),
        .ev       (ev),
        .cd       (cd),
        .a12_prev (a12_prev)
    );

    irqc_count #(.DATA_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .cmd    (cmd),
        .data   (cpu_data),
        .cnt    (cnt),
        .reload (reload),
        .pend   (pend),
        .irq    (irq)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int DATA_W      = 8,
    parameter int EDGE_DELAY  = 25,
    localparam int CD_W       = $clog2(EDGE_DELAY + 1),
    localparam int CNT_W      = DATA_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              vaddr12,
    input irqc_pkg::cmd_t    cmd,
    input logic              ev,
    input logic [CD_W-1:0]   cd,
    input logic              a12_prev,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] reload,
    input logic              pend,
    input logic              irq
);
    // R12
    irq_rise_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev));

    // R11
    ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.irq_off |=> !irq);

    // R12
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev && !cmd.irq_off) |=> $stable(irq));

    // R4
    reload_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && pend) |=> (cnt == {1'b0, $past(reload)} + CNT_W'(1)));

    // R7
    edge_arms_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && vaddr12 && !a12_prev && !cmd.ld_mode) |=> (cd == CD_W'(EDGE_DELAY)));

    // R9
    event_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |-> tick);
endmodule

bind scanline_irq_timer irqc_checker #(
    .DATA_W    (DATA_W),
    .EDGE_DELAY(EDGE_DELAY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .vaddr12  (vaddr12),
    .cmd      (cmd),
    .ev       (ev),
    .cd       (cd),
    .a12_prev (a12_prev),
    .cnt      (cnt),
    .reload   (reload),
    .pend     (pend),
    .irq      (irq)
);

// File: tb/tb_scanline_irq_timer.sv
module tb_scanline_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        tick = 1'b0;
    logic        vaddr12 = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scanline_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .tick(tick), .vaddr12(vaddr12), .irq(irq)
    );

    task automatic chk(input string req, input logic exp);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq=%b expected %b at %0t", req, irq, exp, $time);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // one tick carrying a rising edge, then bit 12 drops between ticks
    task automatic edge_tick();
        vaddr12 = 1'b1;
        ticks(1);
        vaddr12 = 1'b0;
    endtask

    task automatic scanline();
        edge_tick();
        ticks(25);
    endtask

    task automatic ack();
        wr(15'h6000, 8'h00);
        wr(15'h6001, 8'h00);
    endtask

    task automatic t_reset();
        chk("R1 reset irq", 1'b0);
    endtask

    task automatic t_edge_reload();
        wr(15'h4000, 8'd2);
        wr(15'h4001, 8'h00);
        wr(15'h6001, 8'h00);
        scanline(); scanline(); scanline();  // 3,2,1
        chk("R4 reload plus one delays irq", 1'b0);
        ticks(100);
        chk("R8 no event without edge", 1'b0);
        edge_tick();
        ticks(24);
        chk("R7 no event before 25th tick", 1'b0);
        ticks(1);
        chk("R6 irq on decrement to zero", 1'b1);
    endtask

    task automatic t_ack_zero_reload();
        wr(15'h6000, 8'h00);
        chk("R11 disable clears irq", 1'b0);
        wr(15'h6001, 8'h00);
        chk("R11 enable sets nothing", 1'b0);
        scanline(); scanline();              // 0->2, 1
        chk("R5 zero loads reload no irq", 1'b0);
        scanline();                          // 0
        chk("R5 reload then count to zero", 1'b1);
    endtask

    task automatic t_disabled();
        wr(15'h6000, 8'h00);
        scanline(); scanline(); scanline();  // 2,1,0 disabled
        chk("R6 disabled no irq", 1'b0);
        wr(15'h6001, 8'h00);
        chk("R11 late enable no irq", 1'b0);
        scanline(); scanline(); scanline();
        chk("R6 enabled irq", 1'b1);
    endtask

    task automatic t_reload_write();
        ack();
        scanline();                          // 0->2
        wr(15'h5FFE, 8'd5);                  // mirror of reload offset
        wr(15'h2001, 8'hFF);                 // other window, ignored
        scanline();                          // 1
        chk("R2 reload write keeps counter", 1'b0);
        scanline();                          // 0
        chk("R2 counter undisturbed by reload write", 1'b1);
    endtask

    task automatic t_cycle();
        ack();
        wr(15'h4000, 8'd1);
        wr(15'h4001, 8'h01);                 // cycle mode, cd=12, reload req
        ticks(35);
        chk("R3 cycle mode before 36 ticks", 1'b0);
        ticks(1);
        chk("R9 third event at tick 36", 1'b1);
        ack();
        ticks(23);
        chk("R9 free run before next pair", 1'b0);
        ticks(1);
        chk("R9 free run period 12", 1'b1);
    endtask

    task automatic t_collision();
        ack();
        wr(15'h4000, 8'd0);
        wr(15'h4001, 8'h01);                 // cd=12
        ticks(11);
        edge_tick();                         // expiry + edge same tick
        chk("R10 first event no irq", 1'b0);
        ticks(24);
        chk("R10 edge overrides period", 1'b0);
        ticks(1);
        chk("R10 event after 25 ticks", 1'b1);
    endtask

    task automatic t_held_high();
        ack();
        wr(15'h4001, 8'h00);                 // edge mode
        ticks(30);                           // drain leftover countdown
        wr(15'h4001, 8'h00);                 // fresh reload request
        ack();
        vaddr12 = 1'b1;
        ticks(80);                           // one event: cnt=1
        vaddr12 = 1'b0;
        chk("R7 held high no retrigger", 1'b0);
        ticks(1);
        scanline();
        chk("R7 new edge counts", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge_reload();
        t_ack_zero_reload();
        t_disabled();
        t_reload_write();
        t_cycle();
        t_collision();
        t_held_high();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule